// File: doc/BRIEF.md
# Two-Channel Fading Lamp PWM Driver

This block drives two lamp outputs with pulse-width modulation. A free-running counter sets the PWM period: one period is one full count of the counter. Each channel holds a duty value. Its output is high from the start of a period until the counter reaches that duty value. A duty of zero keeps the output dark for the whole period.

At every counter rollover, each channel decides whether it is lit. The channel ANDs a five-bit function word (F1..F4 in bits 3:0, F0 in bit 4) and an eight-bit function word (F5..F12 in bits 7:0) with its own compile-time masks. The travel direction gates the F0 bit in opposite senses on the two channels, so one channel can act as a front light and the other as a rear light. A lit channel ramps its duty up by a fixed step toward its target brightness. A dark channel ramps down by the same step toward zero. Both ramps stop exactly at their end values.

For a short interval after reset, a lit channel jumps straight to its target instead of ramping. This lets brightness return at once after a supply dip resets the block.

Top module: `led_fade_pwm`

## Requirements
- R1: One PWM period is 2**CNT_W clock cycles. Each output is high for exactly as many cycles of a period as the duty value in force for that period. The high cycles come first: the output rises at the counter rollover only when the duty value is nonzero, and falls when the counter equals the duty value.
- R2: A channel is lit when its low mask ANDed with the gated five-bit function word is nonzero, or when its high mask ANDed with the eight-bit function word is nonzero. Otherwise it is dark.
- R3: Channel A ignores the F0 bit (func_lo bit 4) while dir_fwd is 0.
- R4: Channel B ignores the F0 bit (func_lo bit 4) while dir_fwd is 1.
- R5: At a rollover with the jump interval over, a lit channel's duty rises by its STEP. When the gap to TARGET is smaller than STEP, the duty becomes TARGET.
- R6: At a rollover, a dark channel's duty falls by its STEP. When the duty is smaller than STEP, it becomes 0.
- R7: At rollovers 1 through BOOST_WRAPS-1 after reset, a lit channel's duty is set directly to TARGET. From rollover BOOST_WRAPS on, the ramp of R5 applies.
- R8: Reset clears both duty values and drives both outputs low, so the first period after reset is dark.
- R9: The inputs are sampled only at the rollover edge. Input changes during a period do not alter that period's duty or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| func_lo | input | 5 | Function word: bit 4 is F0, bits 3:0 are F4..F1 |
| func_hi | input | 8 | Function word: bits 7:0 are F12..F5 |
| dir_fwd | input | 1 | Direction, 1 = forward, 0 = reverse |
| pwm_a | output | 1 | PWM output of channel A (front) |
| pwm_b | output | 1 | PWM output of channel B (rear) |

## Verification
The inputs are read at the rollover edge. The new duty takes effect from the very next cycle, together with the output's rising edge, and no cycle of delay separates the decision from the period it governs. The bench keeps count of rising edges after reset, so it always knows where the counter is. It changes inputs just before a rollover edge, then samples each output one nanosecond after each of the next 2**CNT_W edges, and compares the number of high samples with a duty value it computes itself. For the test of R9, the bench disturbs the inputs in the middle of a period and restores them before the rollover, so that the count for that period has to stay unaffected.

// File: rtl/fade_pkg.sv
package fade_pkg;
    localparam int FN_LO_W = 5;   // F1..F4 in bits 3:0, F0 in bit 4
    localparam int FN_HI_W = 8;   // F5..F12
    localparam int F0_BIT  = 4;
endpackage

// File: rtl/fade_tick.sv
module fade_tick #(
    parameter int CNT_W       = 16,
    parameter int BOOST_WRAPS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             boost
);
    localparam int WW = $clog2(BOOST_WRAPS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [WW-1:0]    W_LIM   = WW'(BOOST_WRAPS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [WW-1:0]    wraps;
    } tick_t;

    tick_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.cnt = s_q.cnt + 1'b1;
        if (s_q.cnt == CNT_MAX && s_q.wraps != W_LIM)
            s_d.wraps = s_q.wraps + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt   = s_q.cnt;
    assign wrap  = (s_q.cnt == CNT_MAX);
    assign boost = ((int'(s_q.wraps) + 1) < BOOST_WRAPS);

    assert_cnt_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> CNT_W'(s_q.cnt - $past(s_q.cnt)) == CNT_W'(1));
    assert_boost_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wraps <= W_LIM);
    assert_boost_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !boost |=> !boost);
endmodule

// File: rtl/fade_lamp.sv
module fade_lamp
    import fade_pkg::*;
#(
    parameter int                 CNT_W           = 16,
    parameter logic [FN_LO_W-1:0] MASK_LO         = '0,
    parameter logic [FN_HI_W-1:0] MASK_HI         = '0,
    parameter logic [CNT_W-1:0]   TARGET          = '1,
    parameter logic [CNT_W-1:0]   STEP            = 1,
    parameter bit                 F0_OFF_WHEN_FWD = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               wrap,
    input  logic               boost,
    input  logic [FN_LO_W-1:0] func_lo,
    input  logic [FN_HI_W-1:0] func_hi,
    input  logic               dir_fwd,
    output logic               pwm
);
    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic             pwm;
    } lamp_t;

    lamp_t s_d, s_q;
    logic [FN_LO_W-1:0] lo_eff;
    logic               lit, f0_keep;
    logic [CNT_W-1:0]   up_val, dn_val, cnt_nxt;

    always_comb begin
        f0_keep = F0_OFF_WHEN_FWD ? !dir_fwd : dir_fwd;
        lo_eff  = func_lo;
        if (!f0_keep) lo_eff[F0_BIT] = 1'b0;
        lit     = (|(lo_eff & MASK_LO)) || (|(func_hi & MASK_HI));
        up_val  = ((TARGET - s_q.duty) < STEP) ? TARGET : s_q.duty + STEP;
        dn_val  = (s_q.duty < STEP) ? '0 : s_q.duty - STEP;
        cnt_nxt = cnt + 1'b1;

        s_d = s_q;
        if (wrap) begin
            s_d.duty = lit ? (boost ? TARGET : up_val) : dn_val;
            s_d.pwm  = (s_d.duty != '0);
        end else if (cnt_nxt == s_q.duty) begin
            s_d.pwm = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm = s_q.pwm;

    assert_period_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (pwm == (s_q.duty != '0)));
    assert_high_below_duty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pwm |-> (cnt < s_q.duty));
    assert_duty_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.duty <= TARGET);
    assert_hold_between_wraps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(s_q.duty));
    assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !boost) |=> ((s_q.duty >= $past(s_q.duty))
            ? (s_q.duty - $past(s_q.duty)) : ($past(s_q.duty) - s_q.duty)) <= STEP);
endmodule

// File: rtl/led_fade_pwm.sv
module led_fade_pwm
    import fade_pkg::*;
#(
    parameter int                 CNT_W       = 16,
    parameter int                 BOOST_WRAPS = 128,
    parameter logic [FN_LO_W-1:0] MASK_A_LO   = 5'b00001,
    parameter logic [FN_HI_W-1:0] MASK_A_HI   = 8'h00,
    parameter logic [FN_LO_W-1:0] MASK_B_LO   = 5'b00100,
    parameter logic [FN_HI_W-1:0] MASK_B_HI   = 8'h00,
    parameter logic [CNT_W-1:0]   TARGET_A    = 16'h8000,
    parameter logic [CNT_W-1:0]   TARGET_B    = 16'h8000,
    parameter logic [CNT_W-1:0]   STEP_A      = 16'h0100,
    parameter logic [CNT_W-1:0]   STEP_B      = 16'h0800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FN_LO_W-1:0] func_lo,
    input  logic [FN_HI_W-1:0] func_hi,
    input  logic               dir_fwd,
    output logic               pwm_a,
    output logic               pwm_b
);
    localparam int NCH = 2;
    localparam logic [NCH-1:0][FN_LO_W-1:0] M_LO = {MASK_B_LO, MASK_A_LO};
    localparam logic [NCH-1:0][FN_HI_W-1:0] M_HI = {MASK_B_HI, MASK_A_HI};
    localparam logic [NCH-1:0][CNT_W-1:0]   TGT  = {TARGET_B, TARGET_A};
    localparam logic [NCH-1:0][CNT_W-1:0]   STP  = {STEP_B, STEP_A};

    logic [CNT_W-1:0] cnt;
    logic             wrap, boost;
    logic [NCH-1:0]   pwm_w;

    fade_tick #(.CNT_W(CNT_W), .BOOST_WRAPS(BOOST_WRAPS)) u_tick (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .boost(boost)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        fade_lamp #(
            .CNT_W(CNT_W), .MASK_LO(M_LO[i]), .MASK_HI(M_HI[i]),
            .TARGET(TGT[i]), .STEP(STP[i]), .F0_OFF_WHEN_FWD(i == 1)
        ) u_lamp (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .boost(boost),
            .func_lo(func_lo), .func_hi(func_hi), .dir_fwd(dir_fwd),
            .pwm(pwm_w[i])
        );
    end

    assign pwm_a = pwm_w[0];
    assign pwm_b = pwm_w[1];
endmodule

// File: tb/led_fade_pwm_tb.sv
`timescale 1ns/1ps
module led_fade_pwm_tb;
    localparam int CW = 8;
    localparam int PER = 1 << CW;
    localparam int BW = 4;
    localparam int TA = 200, SA = 16, TB = 100, SB = 64;
    localparam logic [4:0] MALO = 5'b10001, MBLO = 5'b10100;
    localparam logic [7:0] MAHI = 8'h01, MBHI = 8'h80;

    logic clk = 0, rst_n = 0, dir_fwd = 1;
    logic [4:0] func_lo = 0;
    logic [7:0] func_hi = 0;
    logic pwm_a, pwm_b;
    int n_run = 0, n_fail = 0;
    int ma = 0, mb = 0, k = 0;

    always #2.5 clk = ~clk;

    led_fade_pwm #(
        .CNT_W(CW), .BOOST_WRAPS(BW),
        .MASK_A_LO(MALO), .MASK_A_HI(MAHI), .MASK_B_LO(MBLO), .MASK_B_HI(MBHI),
        .TARGET_A(8'(TA)), .TARGET_B(8'(TB)), .STEP_A(8'(SA)), .STEP_B(8'(SB))
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .func_lo(func_lo), .func_hi(func_hi),
        .dir_fwd(dir_fwd), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int nxt(int d, bit on, int t, int s, bit bst);
        if (on) return bst ? t : ((t - d < s) ? t : d + s);
        return (d < s) ? 0 : d - s;
    endfunction

    // Inputs are applied here, just before the rollover edge.
    task automatic period(logic [4:0] lo, logic [7:0] hi, logic d, bit glitch, string tag);
        int ha = 0, hb = 0;
        bit fa = 0, fb = 0, on_a, on_b, bst;
        func_lo = lo; func_hi = hi; dir_fwd = d;
        k++;
        bst = (k < BW);
        on_a = ((lo & (d ? 5'h1f : 5'h0f) & MALO) != 0) || ((hi & MAHI) != 0);
        on_b = ((lo & (d ? 5'h0f : 5'h1f) & MBLO) != 0) || ((hi & MBHI) != 0);
        ma = nxt(ma, on_a, TA, SA, bst);
        mb = nxt(mb, on_b, TB, SB, bst);
        for (int i = 0; i < PER; i++) begin
            @(posedge clk); #1;
            if (i == 0) begin fa = pwm_a; fb = pwm_b; end
            ha += pwm_a; hb += pwm_b;
            if (glitch && i == 100) begin func_lo = ~lo; func_hi = ~hi; dir_fwd = ~d; end
            if (glitch && i == 200) begin func_lo = lo; func_hi = hi; dir_fwd = d; end
        end
        check({tag, " R1 A high count"}, ha, ma);
        check({tag, " R1 B high count"}, hb, mb);
        check({tag, " R1 A first level"}, fa, ma != 0);
        check({tag, " R1 B first level"}, fb, mb != 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int h = 0;
        repeat (3) @(negedge clk);
        check("R8 reset pwm_a", pwm_a, 0);
        check("R8 reset pwm_b", pwm_b, 0);
        rst_n = 1;
        for (int i = 1; i < PER; i++) begin
            @(posedge clk); #1;
            h += pwm_a + pwm_b;
        end
        check("R8 first period dark", h, 0);

        period(5'b00000, 8'h00, 1, 0, "R7 off");
        period(5'b00001, 8'h00, 1, 0, "R7 jump A");
        period(5'b00100, 8'h00, 1, 0, "R7 jump B");
        period(5'b00000, 8'h00, 1, 0, "R6 after boost");
        for (int j = 0; j < 14; j++) period(5'b00101, 8'h00, 1, 0, "R5 ramp up");
        period(5'b00101, 8'h00, 1, 1, "R9 mid-period change lit");
        for (int j = 0; j < 14; j++) period(5'b00000, 8'h00, 0, 0, "R6 ramp down");
        period(5'b00000, 8'h00, 0, 1, "R9 mid-period change dark");
        for (int j = 0; j < 4; j++) period(5'b10000, 8'h00, 1, 0, "R3 R4 F0 forward");
        for (int j = 0; j < 4; j++) period(5'b10000, 8'h00, 0, 0, "R3 R4 F0 reverse");
        for (int j = 0; j < 8; j++) period(5'b00000, 8'(1 << j), j[0], 0, "R2 high word");
        for (int d = 0; d < 2; d++)
            for (int lo = 0; lo < 32; lo++)
                period(5'(lo), 8'((lo * 37) & 8'h7e), d[0], 0, "R2 R3 R4 sweep");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule